// File: doc/BRIEF.md
# Burst Prefetch Address Gate

This block sits on the address side of a read path that serves AHB masters from a prefetch buffer. It accepts each AHB address phase and, on every non-sequential request, decides how the request is to be served. It works out how many bytes the whole burst spans, which is beats times bytes per beat. It compares that total with the prefetch length. If the burst does not fit, the block answers with an AHB ERROR response and raises a sticky flag. If the burst fits, the block emits one of two outputs. On a buffer miss it emits a fetch request. For a wrapping burst that fetch starts at the wrap boundary. On a buffer hit it emits a pass-through with the address exactly as the master presented it.

The prefetch length normally comes from a programmed byte count. When that count is zero, the length defined by the selected command sequence is used in its place. The buffer lookup result arrives as an input in the same cycle as the address phase. The flash engine and the read data path belong to other blocks.

A four-state machine orders the work. ST_IDLE means no request is being served. ST_SERVE holds a valid fetch or pass-through for one cycle. ST_ERR_FIRST is the first cycle of the error response, with hready low. ST_ERR_LAST is the second cycle, with hready high.

An accepted NONSEQ request that fits moves the machine from ST_IDLE, ST_SERVE or ST_ERR_LAST into ST_SERVE. An oversize request takes the same three states to ST_ERR_FIRST. With no accepted request those states fall back to ST_IDLE. ST_ERR_FIRST always moves to ST_ERR_LAST.

Top module: `pf_burst_gate`

## Requirements
- R1: hburst is decoded as follows. SINGLE (3'b000) and INCR (3'b001) count as 1 beat. WRAP4/INCR4 (3'b010/3'b011) count as 4 beats, WRAP8/INCR8 (3'b100/3'b101) as 8 beats, and WRAP16/INCR16 (3'b110/3'b111) as 16 beats. The even nonzero codes are the wrapping bursts.
- R2: hsize values 0, 1, 2 and 3 mean 1, 2, 4 and 8 bytes per beat. Any hsize above 3 is treated as oversize and rejected with the error response.
- R3: A NONSEQ request (htrans 2'b10) is accepted while hready is high. It is oversize when beats times bytes per beat exceeds the prefetch length. An oversize request gets a two-cycle response starting the cycle after acceptance. The first cycle has hready=0 and hresp=1. The second cycle has hready=1 and hresp=1.
- R4: err_flag rises in the same cycle as the first error-response cycle and stays high until it is cleared.
- R5: err_flag is cleared by a cycle with err_clr high. If a new error is being set in that same cycle, the set wins.
- R6: The prefetch length is cfg_pf_bytes when that input is nonzero, and seq_pf_bytes when it is zero.
- R7: An accepted wrapping burst that fits and misses the buffer raises fetch_valid with out_addr equal to haddr aligned down to a multiple of its total byte count.
- R8: An accepted SINGLE or incrementing burst that fits and misses the buffer raises fetch_valid with out_addr equal to haddr.
- R9: An accepted burst that fits and hits the buffer raises pass_valid with out_addr equal to haddr, with no alignment even when the burst wraps.
- R10: SEQ (2'b11), BUSY (2'b01) and IDLE (2'b00) transfers produce no fetch, no pass-through and no error, whatever their size.
- R11: While in reset and after it, hready=1, hresp=0, fetch_valid=0, pass_valid=0 and err_flag=0.
- R12: fetch_valid or pass_valid is high for exactly the one cycle after the accepting clock edge, and never both at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| haddr | input | ADDR_W | Address of the address phase |
| htrans | input | 2 | Transfer type |
| hburst | input | 3 | Burst type |
| hsize | input | 3 | Beat size code |
| buf_hit | input | 1 | Buffer lookup result for haddr |
| cfg_pf_bytes | input | LIM_W | Programmed prefetch length in bytes; 0 selects the sequence length |
| seq_pf_bytes | input | LIM_W | Prefetch length from the selected command sequence |
| err_clr | input | 1 | Write-one-to-clear for err_flag |
| hready | output | 1 | Transfer done / slave ready |
| hresp | output | 1 | 0 OKAY, 1 ERROR |
| fetch_valid | output | 1 | One-cycle fetch request on a miss |
| pass_valid | output | 1 | One-cycle pass-through on a hit |
| out_addr | output | ADDR_W | Address of the fetch or pass-through |
| err_flag | output | 1 | Sticky oversize-burst flag |

## Verification
Each burst type is driven at unaligned addresses under both miss and hit. This separates realigned fetches from untouched pass-throughs, and wrapping bursts from incrementing ones. Some totals land exactly on the prefetch length and some just above it. Those show where acceptance turns into the two-cycle error. An hsize beyond 8 bytes exercises the rejection of unsupported sizes. Zeroing the programmed length shows that the sequence length takes over. Non-NONSEQ transfers carrying oversize bursts must leave every output quiet. A clear that coincides with a new error shows which one has priority.

// File: rtl/pf_gate_pkg.sv
package pf_gate_pkg;

    localparam int TOT_W = 8;

    localparam logic [1:0] TR_IDLE   = 2'b00;
    localparam logic [1:0] TR_BUSY   = 2'b01;
    localparam logic [1:0] TR_NONSEQ = 2'b10;
    localparam logic [1:0] TR_SEQ    = 2'b11;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SERVE,
        ST_ERR_FIRST,
        ST_ERR_LAST
    } pf_state_e;

    function automatic logic [2:0] beats_log2(input logic [2:0] burst);
        logic [2:0] r;
        unique case (burst[2:1])
            2'b00:   r = 3'd0;
            2'b01:   r = 3'd2;
            2'b10:   r = 3'd3;
            default: r = 3'd4;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pf_burst_decode.sv
module pf_burst_decode
    import pf_gate_pkg::*;
(
    input  logic [2:0]       burst,
    input  logic [2:0]       size,
    output logic [TOT_W-1:0] total_bytes,
    output logic             is_wrap,
    output logic             size_bad
);

    logic [2:0] shift;

    always_comb begin
        is_wrap  = (burst[0] == 1'b0) && (burst != 3'b000);
        size_bad = (size > 3'd3);
        shift    = beats_log2(burst) + {1'b0, size[1:0]};
        total_bytes = size_bad ? '0 : (TOT_W'(1) << shift);
    end

endmodule

// File: rtl/pf_limit_select.sv
module pf_limit_select #(
    parameter int LIM_W = 8
) (
    input  logic [LIM_W-1:0] cfg_bytes,
    input  logic [LIM_W-1:0] seq_bytes,
    output logic [LIM_W-1:0] limit_bytes
);

    always_comb begin
        limit_bytes = (cfg_bytes != '0) ? cfg_bytes : seq_bytes;
    end

endmodule

// File: rtl/pf_wrap_align.sv
module pf_wrap_align
    import pf_gate_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [TOT_W-1:0]  total_bytes,
    input  logic              is_wrap,
    output logic [ADDR_W-1:0] addr_out
);

    localparam int PAD_W = ADDR_W - TOT_W;

    logic [ADDR_W-1:0] low_mask;

    always_comb begin
        low_mask = {{PAD_W{1'b0}}, total_bytes - TOT_W'(1)};
        addr_out = is_wrap ? (addr_in & ~low_mask) : addr_in;
    end

endmodule

// File: rtl/pf_burst_gate.sv
module pf_burst_gate
    import pf_gate_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LIM_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] haddr,
    input  logic [1:0]        htrans,
    input  logic [2:0]        hburst,
    input  logic [2:0]        hsize,
    input  logic              buf_hit,
    input  logic [LIM_W-1:0]  cfg_pf_bytes,
    input  logic [LIM_W-1:0]  seq_pf_bytes,
    input  logic              err_clr,
    output logic              hready,
    output logic              hresp,
    output logic              fetch_valid,
    output logic              pass_valid,
    output logic [ADDR_W-1:0] out_addr,
    output logic              err_flag
);

    localparam int CMP_W = (LIM_W > TOT_W) ? LIM_W : TOT_W;

    pf_state_e         state_q, state_d;
    logic [TOT_W-1:0]  total_bytes;
    logic              is_wrap;
    logic              size_bad;
    logic [LIM_W-1:0]  limit_bytes;
    logic [ADDR_W-1:0] wrap_addr;
    logic              accept;
    logic              oversize;
    logic [ADDR_W-1:0] addr_q;
    logic              hit_q;

    pf_burst_decode u_decode (
        .burst       (hburst),
        .size        (hsize),
        .total_bytes (total_bytes),
        .is_wrap     (is_wrap),
        .size_bad    (size_bad)
    );

    pf_limit_select #(.LIM_W(LIM_W)) u_limit (
        .cfg_bytes   (cfg_pf_bytes),
        .seq_bytes   (seq_pf_bytes),
        .limit_bytes (limit_bytes)
    );

    pf_wrap_align #(.ADDR_W(ADDR_W)) u_align (
        .addr_in     (haddr),
        .total_bytes (total_bytes),
        .is_wrap     (is_wrap),
        .addr_out    (wrap_addr)
    );

    always_comb begin
        accept   = hready && (htrans == TR_NONSEQ);
        oversize = size_bad || (CMP_W'(total_bytes) > CMP_W'(limit_bytes));
    end

    // next-state logic
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_ERR_FIRST: state_d = ST_ERR_LAST;
            ST_IDLE, ST_SERVE, ST_ERR_LAST: begin
                if (accept) state_d = oversize ? ST_ERR_FIRST : ST_SERVE;
                else        state_d = ST_IDLE;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // captured request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            hit_q  <= 1'b0;
        end else if (accept && !oversize) begin
            addr_q <= buf_hit ? haddr : wrap_addr;
            hit_q  <= buf_hit;
        end
    end

    // sticky flag, set over clear
    always_ff @(posedge clk) begin
        if (!rst_n)                 err_flag <= 1'b0;
        else if (accept && oversize) err_flag <= 1'b1;
        else if (err_clr)           err_flag <= 1'b0;
    end

    // outputs
    always_comb begin
        hready      = 1'b1;
        hresp       = 1'b0;
        fetch_valid = 1'b0;
        pass_valid  = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_SERVE: begin
                fetch_valid = !hit_q;
                pass_valid  = hit_q;
            end
            ST_ERR_FIRST: begin
                hready = 1'b0;
                hresp  = 1'b1;
            end
            ST_ERR_LAST: hresp = 1'b1;
        endcase
        out_addr = addr_q;
    end

endmodule

// File: rtl/pf_burst_gate_chk.sv
module pf_burst_gate_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] haddr,
    input logic [1:0]        htrans,
    input logic [2:0]        hburst,
    input logic              hready,
    input logic              hresp,
    input logic              fetch_valid,
    input logic              pass_valid,
    input logic [ADDR_W-1:0] out_addr,
    input logic              err_flag,
    input logic              err_clr
);

    a_r3_err_second_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (hresp && !hready) |=> (hresp && hready));

    a_r3_wait_only_on_error: assert property (@(posedge clk) disable iff (!rst_n)
        !hready |-> hresp);

    a_r4_flag_with_error: assert property (@(posedge clk) disable iff (!rst_n)
        (hresp && !hready) |-> err_flag);

    a_r5_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
        err_clr |=> (!err_flag || (hresp && !hready)));

    a_r12_one_kind: assert property (@(posedge clk) disable iff (!rst_n)
        !(fetch_valid && pass_valid));

    a_r10_only_after_nonseq: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid || pass_valid) |-> $past(htrans == 2'b10 && hready));

    a_r9_hit_addr_kept: assert property (@(posedge clk) disable iff (!rst_n)
        pass_valid |-> (out_addr == $past(haddr)));

    a_r8_incr_addr_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && $past(hburst[0] || hburst == 3'b000)) |-> (out_addr == $past(haddr)));

endmodule

bind pf_burst_gate pf_burst_gate_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .haddr       (haddr),
    .htrans      (htrans),
    .hburst      (hburst),
    .hready      (hready),
    .hresp       (hresp),
    .fetch_valid (fetch_valid),
    .pass_valid  (pass_valid),
    .out_addr    (out_addr),
    .err_flag    (err_flag),
    .err_clr     (err_clr)
);

// File: tb/pf_burst_gate_tb.sv
`timescale 1ns/1ps
module pf_burst_gate_tb;

    localparam int NV = 12;
    // kind: 1 fetch, 2 pass, 3 error
    localparam logic [31:0] T_ADDR [NV] = '{
        32'h1000_0013, 32'h1000_0013, 32'h2000_0036, 32'h0000_007C,
        32'h0000_007C, 32'h0000_0005, 32'h0000_00AB, 32'h0000_0F0F,
        32'h0000_0F0F, 32'h0000_0040, 32'h0000_0044, 32'h0000_0010};
    localparam logic [2:0] T_BURST [NV] = '{
        3'd2, 3'd2, 3'd5, 3'd4, 3'd6, 3'd0, 3'd1, 3'd6, 3'd2, 3'd7, 3'd4, 3'd0};
    localparam logic [2:0] T_SIZE [NV] = '{
        3'd2, 3'd2, 3'd1, 3'd2, 3'd2, 3'd3, 3'd0, 3'd0, 3'd3, 3'd3, 3'd3, 3'd4};
    localparam logic T_HIT [NV] = '{
        1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0};
    localparam logic [1:0] T_KIND [NV] = '{
        2'd1, 2'd2, 2'd1, 2'd1, 2'd3, 2'd1, 2'd2, 2'd1, 2'd1, 2'd3, 2'd3, 2'd3};
    localparam logic [31:0] T_EXP [NV] = '{
        32'h1000_0010, 32'h1000_0013, 32'h2000_0036, 32'h0000_0060,
        32'h0, 32'h0000_0005, 32'h0000_00AB, 32'h0000_0F00,
        32'h0000_0F00, 32'h0, 32'h0, 32'h0};

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] haddr;
    logic [1:0]  htrans;
    logic [2:0]  hburst, hsize;
    logic        buf_hit;
    logic [7:0]  cfg_pf_bytes, seq_pf_bytes;
    logic        err_clr;
    logic        hready, hresp, fetch_valid, pass_valid, err_flag;
    logic [31:0] out_addr;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pf_burst_gate u_dut (
        .clk(clk), .rst_n(rst_n), .haddr(haddr), .htrans(htrans),
        .hburst(hburst), .hsize(hsize), .buf_hit(buf_hit),
        .cfg_pf_bytes(cfg_pf_bytes), .seq_pf_bytes(seq_pf_bytes),
        .err_clr(err_clr), .hready(hready), .hresp(hresp),
        .fetch_valid(fetch_valid), .pass_valid(pass_valid),
        .out_addr(out_addr), .err_flag(err_flag));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] outs();
        return {28'd0, fetch_valid, pass_valid, hready, hresp};
    endfunction

    task automatic drive(input logic [31:0] a, input logic [1:0] t,
                         input logic [2:0] b, input logic [2:0] s, input logic h);
        haddr = a; htrans = t; hburst = b; hsize = s; buf_hit = h;
    endtask

    task automatic clear_flag();
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0; err_clr = 1'b0;
        cfg_pf_bytes = 8'd32; seq_pf_bytes = 8'd64;
        drive(32'h0, 2'b00, 3'd0, 3'd0, 1'b0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R11 outputs in reset", outs(), 32'h2);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 outputs after reset", outs(), 32'h2);
        chk("R11 flag after reset", {31'd0, err_flag}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            drive(T_ADDR[i], 2'b10, T_BURST[i], T_SIZE[i], T_HIT[i]);
            @(negedge clk);
            htrans = 2'b00;
            if (T_KIND[i] == 2'd3) begin
                chk("R1 R2 R3 error first cycle", outs(), 32'h1);
                chk("R4 flag set", {31'd0, err_flag}, 32'd1);
                @(negedge clk);
                chk("R3 error second cycle", outs(), 32'h3);
                @(negedge clk);
                chk("R3 back to idle", outs(), 32'h2);
                chk("R4 flag sticky", {31'd0, err_flag}, 32'd1);
                clear_flag();
                chk("R5 flag cleared", {31'd0, err_flag}, 32'd0);
            end else begin
                chk(T_KIND[i] == 2'd1 ? "R1 R2 R7 R8 fetch" : "R9 pass",
                    outs(), T_KIND[i] == 2'd1 ? 32'hA : 32'h6);
                chk(T_KIND[i] == 2'd1 ? "R7 R8 fetch addr" : "R9 pass addr",
                    out_addr, T_EXP[i]);
                @(negedge clk);
                chk("R12 one cycle", outs(), 32'h2);
            end
        end

        // R6: zero programmed length falls back to sequence length
        cfg_pf_bytes = 8'd0; seq_pf_bytes = 8'd64;
        drive(32'h0000_007C, 2'b10, 3'd6, 3'd2, 1'b0);
        @(negedge clk);
        htrans = 2'b00;
        chk("R6 fallback accepts 64", outs(), 32'hA);
        chk("R6 R7 fallback addr", out_addr, 32'h0000_0040);
        seq_pf_bytes = 8'd16;
        drive(32'h0000_007C, 2'b10, 3'd4, 3'd2, 1'b0);
        @(negedge clk);
        htrans = 2'b00;
        chk("R6 fallback rejects 32", outs(), 32'h1);
        repeat (2) @(negedge clk);
        clear_flag();
        cfg_pf_bytes = 8'd32; seq_pf_bytes = 8'd64;

        // R10: non-NONSEQ transfers do nothing
        drive(32'h0000_0100, 2'b11, 3'd7, 3'd3, 1'b0);
        @(negedge clk);
        chk("R10 SEQ ignored", outs(), 32'h2);
        chk("R10 SEQ no flag", {31'd0, err_flag}, 32'd0);
        htrans = 2'b01;
        @(negedge clk);
        chk("R10 BUSY ignored", outs(), 32'h2);
        chk("R10 BUSY no flag", {31'd0, err_flag}, 32'd0);
        htrans = 2'b00;
        @(negedge clk);

        // R5: set wins over simultaneous clear
        drive(32'h0000_0200, 2'b10, 3'd7, 3'd3, 1'b0);
        err_clr = 1'b1;
        @(negedge clk);
        htrans = 2'b00; err_clr = 1'b0;
        chk("R5 set beats clear", {31'd0, err_flag}, 32'd1);
        repeat (2) @(negedge clk);
        clear_flag();
        chk("R5 later clear", {31'd0, err_flag}, 32'd0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule